// File: doc/BRIEF.md
# Wide-to-Narrow Read Data Gasket

This block joins a requester with a narrow read data path to a memory port that is twice as wide. A read request from the narrow side (address plus burst length in wide entries) is passed on to the memory side unchanged. The memory streams back one wide entry per cycle and cannot be stalled. Each entry lands in an internal buffer and then leaves on the narrow side as two half-width beats.

Because the memory can return data at full rate while the requester drains at half rate or slower, a request is only let through when the buffer has room reserved for every entry it will bring back. A free-space counter is charged with the whole burst when a request is handed to memory. It gets one unit back each time a buffered entry has fully left on the narrow side. Bursts up to the largest encodable length, 16 entries or 32 narrow words by default, run to completion with no lost data and no deadlock.

Top module: `wide_narrow_rd_gasket`

## Requirements
- R1: After reset `nrw_valid` and `mem_req_valid` are low, and all buffer space is free, so a maximum-length request offered while `mem_req_ready` is high is accepted on the first cycle.
- R2: `req_len` encodes the burst as entries minus one (0 means 1 entry, 15 means 16 entries). While a request is admitted, `mem_req_valid` follows `req_valid`, `mem_req_addr` and `mem_req_len` equal `req_addr` and `req_len`, and `req_ready` is high only while `mem_req_ready` is high.
- R3: A request is passed to memory only while the unreserved buffer space is at least its entry count. Otherwise `req_ready` and `mem_req_valid` stay low. Buffered entries never exceed the buffer depth, even with a return every cycle and no narrow draining.
- R4: Each wide entry leaves as two narrow beats: bits [31:0] first, then bits [63:32].
- R5: `nrw_last` is high only on the second narrow beat of the entry that arrived with `mem_rd_last` high.
- R6: Space reserved for an entry is released only when its second narrow beat is accepted, and not after the first beat alone.
- R7: While `nrw_valid` is high and `nrw_ready` is low, `nrw_valid`, `nrw_data` and `nrw_last` hold their values into the next cycle.
- R8: A burst of 16 entries is delivered as 32 narrow beats in order, with `nrw_last` on the final beat.
- R9: Under random narrow-side backpressure and full-rate memory returns, every word of every burst arrives once, in request order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Narrow-side read request valid |
| req_ready | output | 1 | Request accepted this cycle |
| req_addr | input | ADDR_W | Request address |
| req_len | input | LEN_W | Burst length in wide entries minus one |
| mem_req_valid | output | 1 | Request offered to memory |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_addr | output | ADDR_W | Forwarded address |
| mem_req_len | output | LEN_W | Forwarded length |
| mem_rd_valid | input | 1 | Wide return entry valid (cannot be stalled) |
| mem_rd_data | input | 2*NARROW_W | Wide return data |
| mem_rd_last | input | 1 | Final entry of a burst |
| nrw_valid | output | 1 | Narrow beat valid |
| nrw_ready | input | 1 | Requester accepts the narrow beat |
| nrw_data | output | NARROW_W | Narrow beat data |
| nrw_last | output | 1 | Final narrow beat of a burst |

## Verification
Space can be reserved by a newly admitted request in the same cycle that an entry's second narrow beat releases space. The net change to the free count must then be the burst size minus one. The bench provokes this with random narrow backpressure while requests of random length keep arriving and memory returns one entry every cycle. It judges the result by buffer occupancy, computed at the ports from entries returned minus entry pairs consumed and never above the depth, and by the scoreboard finding every word in order. A directed stall phase pins down the exact cycle at which a held request gets in after one entry drains.

// File: rtl/gsk_pkg.sv
package gsk_pkg;

   // which half of the head entry the narrow port is presenting
   typedef enum logic {
      HALF_FIRST  = 1'b0,
      HALF_SECOND = 1'b1
   } half_e;

endpackage

// File: rtl/gsk_fifo.sv
module gsk_fifo #(
   parameter int WIDTH = 65,
   parameter int DEPTH = 32,
   parameter int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] din,
   input  logic             pop,
   output logic [WIDTH-1:0] dout,
   output logic             empty,
   output logic             full,
   output logic [CNT_W-1:0] count
);

   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam bit POW2  = ((DEPTH & (DEPTH - 1)) == 0);

   if (DEPTH < 2) begin : g_bad_depth
      $error("gsk_fifo: DEPTH must be at least 2");
   end

   logic [WIDTH-1:0] store [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [CNT_W-1:0] cnt_q;

   // pointer advance: free wrap for power-of-two depths, compare otherwise
   if (POW2) begin : g_wrap_pow2
      assign wr_nxt = wr_ptr + PTR_W'(1);
      assign rd_nxt = rd_ptr + PTR_W'(1);
   end else begin : g_wrap_cmp
      assign wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + PTR_W'(1);
      assign rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + PTR_W'(1);
   end

   always_ff @(posedge clk) begin
      if (push) store[wr_ptr] <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt_q  <= '0;
      end else begin
         if (push) wr_ptr <= wr_nxt;
         if (pop)  rd_ptr <= rd_nxt;
         case ({push, pop})
            2'b10:   cnt_q <= cnt_q + CNT_W'(1);
            2'b01:   cnt_q <= cnt_q - CNT_W'(1);
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   assign dout  = store[rd_ptr];
   assign empty = (cnt_q == '0);
   assign full  = (cnt_q == CNT_W'(DEPTH));
   assign count = cnt_q;

   // R3: a return entry never arrives while the buffer is full
   p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full)
      else $error("buffer overflow");

   p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty)
      else $error("buffer underflow");

endmodule

// File: rtl/gsk_credit.sv
module gsk_credit #(
   parameter int DEPTH = 32,
   parameter int LEN_W = 4,
   parameter int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LEN_W-1:0] need_len,
   input  logic             issue,
   input  logic             give_back,
   output logic             room_ok,
   output logic [CNT_W-1:0] credits
);

   logic [CNT_W-1:0] cred_q;
   logic [CNT_W-1:0] need;
   logic [CNT_W-1:0] charge;

   assign need    = CNT_W'(need_len) + CNT_W'(1);
   assign room_ok = (cred_q >= need);
   assign charge  = issue ? need : '0;

   // reservation and release may land in the same cycle
   always_ff @(posedge clk) begin
      if (!rst_n) cred_q <= CNT_W'(DEPTH);
      else        cred_q <= cred_q - charge + (give_back ? CNT_W'(1) : CNT_W'(0));
   end

   assign credits = cred_q;

   // R3: the free count never exceeds the buffer depth
   p_credit_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cred_q <= CNT_W'(DEPTH))
      else $error("credit count above depth");

   // R3: an issued request always found its space
   p_issue_covered_r3: assert property (@(posedge clk) disable iff (!rst_n)
      issue |-> (cred_q >= need))
      else $error("request issued without space");

endmodule

// File: rtl/gsk_unpack.sv
module gsk_unpack
   import gsk_pkg::*;
#(
   parameter int NARROW_W = 32,
   parameter bit HI_FIRST = 1'b0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  in_valid,
   input  logic [2*NARROW_W-1:0] in_data,
   input  logic                  in_last,
   output logic                  in_pop,
   output logic                  out_valid,
   input  logic                  out_ready,
   output logic [NARROW_W-1:0]   out_data,
   output logic                  out_last
);

   half_e half_q;
   logic [NARROW_W-1:0] lo_w, hi_w, first_w, second_w;
   logic beat_go;

   assign lo_w = in_data[NARROW_W-1:0];
   assign hi_w = in_data[2*NARROW_W-1:NARROW_W];

   // word order variant
   if (HI_FIRST) begin : g_hi_first
      assign first_w  = hi_w;
      assign second_w = lo_w;
   end else begin : g_lo_first
      assign first_w  = lo_w;
      assign second_w = hi_w;
   end

   assign beat_go   = in_valid && out_ready;
   assign out_valid = in_valid;
   assign out_data  = (half_q == HALF_SECOND) ? second_w : first_w;
   assign out_last  = in_last && (half_q == HALF_SECOND);
   assign in_pop    = beat_go && (half_q == HALF_SECOND);

   always_ff @(posedge clk) begin
      if (!rst_n)       half_q <= HALF_FIRST;
      else if (beat_go) half_q <= (half_q == HALF_FIRST) ? HALF_SECOND : HALF_FIRST;
   end

   // R7: an unaccepted beat stays put
   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)))
      else $error("narrow beat changed under backpressure");

endmodule

// File: rtl/wide_narrow_rd_gasket.sv
module wide_narrow_rd_gasket
   import gsk_pkg::*;
#(
   parameter int NARROW_W   = 32,
   parameter int ADDR_W     = 32,
   parameter int LEN_W      = 4,
   parameter int FIFO_DEPTH = 32,
   parameter bit HI_FIRST   = 1'b0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_valid,
   output logic                  req_ready,
   input  logic [ADDR_W-1:0]     req_addr,
   input  logic [LEN_W-1:0]      req_len,
   output logic                  mem_req_valid,
   input  logic                  mem_req_ready,
   output logic [ADDR_W-1:0]     mem_req_addr,
   output logic [LEN_W-1:0]      mem_req_len,
   input  logic                  mem_rd_valid,
   input  logic [2*NARROW_W-1:0] mem_rd_data,
   input  logic                  mem_rd_last,
   output logic                  nrw_valid,
   input  logic                  nrw_ready,
   output logic [NARROW_W-1:0]   nrw_data,
   output logic                  nrw_last
);

   localparam int WIDE_W    = 2 * NARROW_W;
   localparam int ENTRY_W   = WIDE_W + 1;
   localparam int MAX_BURST = 1 << LEN_W;
   localparam int CNT_W     = $clog2(FIFO_DEPTH + 1);

   if (FIFO_DEPTH < MAX_BURST) begin : g_bad_cfg
      $error("wide_narrow_rd_gasket: FIFO_DEPTH must hold one longest burst");
   end
   if (NARROW_W < 1 || ADDR_W < 1 || LEN_W < 1) begin : g_bad_width
      $error("wide_narrow_rd_gasket: widths must be positive");
   end

   logic             room_ok, issue, give_back;
   logic [CNT_W-1:0] credits, fill;
   logic [ENTRY_W-1:0] head;
   logic             fifo_empty, fifo_full;

   // request admission
   assign mem_req_valid = req_valid && room_ok;
   assign req_ready     = mem_req_ready && room_ok;
   assign mem_req_addr  = req_addr;
   assign mem_req_len   = req_len;
   assign issue         = mem_req_valid && mem_req_ready;

   gsk_credit #(
      .DEPTH (FIFO_DEPTH),
      .LEN_W (LEN_W),
      .CNT_W (CNT_W)
   ) i_credit (
      .clk       (clk),
      .rst_n     (rst_n),
      .need_len  (req_len),
      .issue     (issue),
      .give_back (give_back),
      .room_ok   (room_ok),
      .credits   (credits)
   );

   gsk_fifo #(
      .WIDTH (ENTRY_W),
      .DEPTH (FIFO_DEPTH),
      .CNT_W (CNT_W)
   ) i_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (mem_rd_valid),
      .din   ({mem_rd_last, mem_rd_data}),
      .pop   (give_back),
      .dout  (head),
      .empty (fifo_empty),
      .full  (fifo_full),
      .count (fill)
   );

   gsk_unpack #(
      .NARROW_W (NARROW_W),
      .HI_FIRST (HI_FIRST)
   ) i_unpack (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (!fifo_empty),
      .in_data   (head[WIDE_W-1:0]),
      .in_last   (head[WIDE_W]),
      .in_pop    (give_back),
      .out_valid (nrw_valid),
      .out_ready (nrw_ready),
      .out_data  (nrw_data),
      .out_last  (nrw_last)
   );

   // R3: free space plus stored entries never exceed the buffer
   p_space_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ({1'b0, credits} + {1'b0, fill}) <= (CNT_W + 1)'(FIFO_DEPTH))
      else $error("space accounting exceeds depth");

   // R3: with the buffer full there is no free space left to grant
   p_full_no_room_r3: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_full |-> (credits == '0))
      else $error("space granted while buffer full");

endmodule

// File: tb/test_wide_narrow_rd_gasket.sv
`timescale 1ns/1ps
module test_wide_narrow_rd_gasket;

   localparam int DEPTH = 32;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_addr = '0;
   logic [3:0]  req_len = '0;
   logic        mem_req_valid;
   logic        mem_req_ready = 1'b1;
   logic [31:0] mem_req_addr;
   logic [3:0]  mem_req_len;
   logic        mem_rd_valid = 1'b0;
   logic [63:0] mem_rd_data = '0;
   logic        mem_rd_last = 1'b0;
   logic        nrw_valid;
   logic        nrw_ready = 1'b0;
   logic [31:0] nrw_data;
   logic        nrw_last;

   always #10 clk = ~clk;

   wide_narrow_rd_gasket i_wide_narrow_rd_gasket (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_len(req_len),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_addr(mem_req_addr), .mem_req_len(mem_req_len),
      .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data), .mem_rd_last(mem_rd_last),
      .nrw_valid(nrw_valid), .nrw_ready(nrw_ready), .nrw_data(nrw_data), .nrw_last(nrw_last)
   );

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [32:0] exp_q[$];
   typedef struct { logic [31:0] addr; int len; } mreq_t;
   mreq_t pend[$];
   int beat_idx = 0;
   int sent_entries = 0;
   int took_beats = 0;
   int max_occ = 0;
   int mode = 0;        // 0 hold low, 1 random, 2 always, 3 counted grants
   int grant_left = 0;

   task automatic check(input bit ok, input string rq, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
      end
   endtask

   function automatic logic [63:0] wbeat(input logic [31:0] a, input int i);
      logic [31:0] lo, hi;
      lo = {a[15:0], 8'(2*i), 8'h11};
      hi = {a[15:0], 8'(2*i+1), 8'h22};
      return {hi, lo};
   endfunction

   task automatic push_expected(input logic [31:0] a, input int entries);
      for (int i = 0; i < entries; i++) begin
         logic [63:0] w;
         w = wbeat(a, i);
         exp_q.push_back({1'b0, w[31:0]});
         exp_q.push_back({(i == entries - 1), w[63:32]});
      end
   endtask

   // memory model: one entry per cycle, never stalls
   initial forever begin
      @(negedge clk);
      #2;
      mem_rd_valid = 1'b0;
      mem_rd_last  = 1'b0;
      if (rst_n && pend.size() > 0) begin
         mem_rd_valid = 1'b1;
         mem_rd_data  = wbeat(pend[0].addr, beat_idx);
         mem_rd_last  = (beat_idx == pend[0].len - 1);
         sent_entries++;
         if (beat_idx == pend[0].len - 1) begin
            void'(pend.pop_front());
            beat_idx = 0;
         end else begin
            beat_idx++;
         end
      end
      if (rst_n && mem_req_valid && mem_req_ready) begin
         mreq_t m;
         m.addr = mem_req_addr;
         m.len  = int'(mem_req_len) + 1;
         pend.push_back(m);
      end
   end

   // narrow-side monitor and scoreboard
   initial begin
      bit held = 1'b0;
      logic [32:0] held_v = '0;
      forever begin
         @(negedge clk);
         case (mode)
            0: nrw_ready = 1'b0;
            1: nrw_ready = 1'($urandom % 2);
            2: nrw_ready = 1'b1;
            default: nrw_ready = (grant_left > 0);
         endcase
         #3;
         if (rst_n) begin
            if (held)
               check(nrw_valid && {nrw_last, nrw_data} == held_v, "R7", "held beat",
                     {31'b0, nrw_valid, nrw_last, nrw_data}, {32'b1, held_v});
            held   = nrw_valid && !nrw_ready;
            held_v = {nrw_last, nrw_data};
            if (nrw_valid && nrw_ready) begin
               if (exp_q.size() == 0) begin
                  check(1'b0, "R9", "unexpected beat", {31'b0, nrw_last, nrw_data}, '0);
               end else begin
                  logic [32:0] e;
                  e = exp_q.pop_front();
                  check(nrw_data == e[31:0], "R4", "word order/data", nrw_data, e[31:0]);
                  check(nrw_last == e[32], "R5", "last flag", nrw_last, e[32]);
               end
               took_beats++;
               if (mode == 3) grant_left--;
            end
            if (sent_entries - took_beats / 2 > max_occ) max_occ = sent_entries - took_beats / 2;
         end
      end
   end

   // returns cycles waited before acceptance
   task automatic issue(input logic [31:0] a, input int entries, output int waited);
      waited = 0;
      @(negedge clk);
      #1;
      req_valid = 1'b1;
      req_addr  = a;
      req_len   = 4'(entries - 1);
      forever begin
         #3;
         if (req_ready) begin
            check(mem_req_valid && mem_req_addr == a && mem_req_len == 4'(entries - 1), "R2",
                  "forwarded request", {mem_req_valid, mem_req_len, mem_req_addr},
                  {1'b1, 4'(entries - 1), a});
            push_expected(a, entries);
            break;
         end
         waited++;
         @(negedge clk);
         #1;
      end
      @(negedge clk);
      #1;
      req_valid = 1'b0;
   endtask

   task automatic wait_drain(input string rq);
      int n = 0;
      while ((exp_q.size() != 0 || pend.size() != 0) && n < 5000) begin
         @(negedge clk);
         n++;
      end
      repeat (3) @(negedge clk);
      check(exp_q.size() == 0, rq, "all beats delivered", exp_q.size(), 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL R9 watchdog expired: actual hung expected done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int w;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #4;
      check(!nrw_valid, "R1", "nrw_valid after reset", nrw_valid, 0);
      check(!mem_req_valid, "R1", "mem_req_valid after reset", mem_req_valid, 0);

      // longest burst straight after reset, drained at full speed
      mode = 2;
      issue(32'h0100, 16, w);
      check(w == 0, "R1", "max burst admitted at once", w, 0);
      wait_drain("R8");
      issue(32'h0200, 1, w);
      wait_drain("R4");

      // memory not ready: nothing accepted, request still offered
      @(negedge clk);
      #1;
      mem_req_ready = 1'b0;
      req_valid = 1'b1; req_addr = 32'h0250; req_len = 4'd0;
      repeat (3) begin
         #3;
         check(!req_ready && mem_req_valid, "R2", "ready follows memory",
               {req_ready, mem_req_valid}, 2'b01);
         @(negedge clk);
         #1;
      end
      req_valid = 1'b0;
      mem_req_ready = 1'b1;

      // fill with no draining, then check admission and release timing
      mode = 0;
      issue(32'h0300, 16, w);
      issue(32'h0400, 16, w);
      repeat (40) @(negedge clk);
      check(sent_entries - took_beats / 2 == DEPTH, "R3", "buffer full of returns",
            sent_entries - took_beats / 2, DEPTH);
      #1;
      req_valid = 1'b1; req_addr = 32'h0500; req_len = 4'd0;
      begin
         int seen = 0;
         repeat (10) begin
            #3;
            if (req_ready || mem_req_valid) seen++;
            @(negedge clk);
            #1;
         end
         check(seen == 0, "R3", "request held without space", seen, 0);
      end
      #3;
      grant_left = 1; mode = 3;
      @(negedge clk);
      @(negedge clk);
      #4;
      check(!req_ready, "R6", "no release after first half", req_ready, 0);
      grant_left = 1;
      @(negedge clk);
      @(negedge clk);
      #4;
      check(req_ready, "R6", "release after second half", req_ready, 1);
      if (req_ready) push_expected(32'h0500, 1);
      @(negedge clk);
      #1;
      req_valid = 1'b0;
      mode = 1;
      wait_drain("R9");

      // random lengths under random backpressure
      for (int k = 0; k < 40; k++)
         issue(32'h1000 + 32'(k) * 32'h10, int'($urandom % 16) + 1, w);
      issue(32'h2000, 16, w);
      wait_drain("R9");
      check(max_occ <= DEPTH, "R3", "peak occupancy", max_occ, DEPTH);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule